// File: doc/BRIEF.md
# Five-Level H-Bridge Leg Seven-Segment Switching Sequencer

This block turns one triangle of a five-level space-vector diagram into a full switching period of phase levels, and then into gate signals. A modulator upstream supplies the candidate states of the virtual zero vertex and of the two active vertices, each as a list of redundant three-phase states. It also supplies two active dwell times. The block picks two neighbouring zero states and one state from each active vertex so that the period runs zero, active, active, alternate zero, and then the same states back again. Every step inside the period moves exactly one phase by one level.

A free-running counter sets the period. Inputs are sampled only on the period boundary. The chosen three-phase level is decoded into eight gate bits per phase for an H-bridge built from two neutral-point-clamped legs. If no ordering with single steps exists for the offered states, an error flag is raised for that period and the outputs stay frozen.

Top module: `hnpc_seq7`

## Requirements
- R1: While `rst_n` is low, `level_o` is 9'o222, `gate_o` is 24'h666666 and `err_o` is 0. The first rising edge after reset release is a period boundary.
- R2: A level code runs from 0 (−2E) to 4 (+2E). Phase a sits in `level_o[8:6]` and `gate_o[23:16]`, phase b in [5:3] and [15:8], phase c in [2:0] and [7:0]. Each gate byte is {S11,S12,S13,S14,S21,S22,S23,S24}, MSB first: code 0→8'hC3, 1→8'h63, 2→8'h66, 3→8'h36, 4→8'h3C.
- R3: In a period the states are Z0, V1, V2, Z1, V2, V1, Z0. Here V1 = Z0 plus one level on one phase, V2 = V1 plus one level on one phase, and Z1 = V2 plus one level on one phase. V1 and V2 may come from either active vertex, in either order.
- R4: Zero states are listed lowest first. Z0 and Z1 are adjacent entries i and i+1 of that list. The highest i that gives a valid ordering is used, so the last valid entry is never the start state.
- R5: With T0 = P − T1 − T2, the segment lengths in clock cycles are: first Z0 floor(T0/4); V1 floor(T1/2); V2 floor(T2/2); Z1 T0 − floor(T0/2); V2 T2 − floor(T2/2); V1 T1 − floor(T1/2); last Z0 floor(T0/2) − floor(T0/4). A segment of length zero is skipped.
- R6: T1 is clamped to P. T2 is then clamped to P − T1.
- R7: Inputs are sampled only at the boundary edge B. The level for cycle j of the period appears after edge B+1+j. `err_o` changes only on edge B+1.
- R8: If no valid ordering exists, including when fewer than two zero states are offered, `err_o` is 1 for that period and `level_o` and `gate_o` hold the last value of the previous period.
- R9: Within a period whose seven segments all have nonzero length, every change of `level_o` moves exactly one phase by exactly one level.
- R10: In every leg, S11 is the complement of S13 and S12 is the complement of S14. The same holds for S21/S23 and S22/S24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zero_set_i | input | 9*NZR | Zero-vertex states, entry k in bits [9k+8:9k], lowest first |
| zero_cnt_i | input | $clog2(NZR+1) | Number of valid zero states |
| vtx_a_i | input | 9*NAR | Redundant states of the first active vertex |
| vtx_a_cnt_i | input | $clog2(NAR+1) | Number of valid states in `vtx_a_i` |
| vtx_b_i | input | 9*NAR | Redundant states of the second active vertex |
| vtx_b_cnt_i | input | $clog2(NAR+1) | Number of valid states in `vtx_b_i` |
| t1_i | input | $clog2(P+1) | First active dwell, in clock cycles |
| t2_i | input | $clog2(P+1) | Second active dwell, in clock cycles |
| level_o | output | 9 | Present three-phase level code |
| gate_o | output | 24 | Gate bits for the three phases |
| err_o | output | 1 | No single-step ordering for this period |

## Verification
The hardest situation to reach from the ports is a change of inputs in the middle of a period, which must not disturb the pattern already running. The stimulus therefore applies each new state set and dwell pair halfway through the preceding period, so every period overlaps a pending change.

Error recovery is reached by two infeasible periods in a row, one of them with a single zero state, followed by a feasible set. This shows the held level survives more than one period and that the hold is released on the next boundary.

Priority is covered by a five-entry zero list and by a three-entry list where only the lowest pair fits.

// File: rtl/hnpc_seq7_pkg.sv
// Shared types and helpers for the seven-segment H-bridge sequencer.
// Assumes three phases, each carrying a 3-bit level code in the range 0..4.
package hnpc_seq7_pkg;

    localparam int PHASES = 3;
    localparam int LVL_W  = 3;
    localparam int ST_W   = PHASES * LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [ST_W-1:0]  state_t;

    // True when 'to' equals 'from' with one phase raised by one level
    function automatic logic step_up(input state_t from, input state_t to);
        int  ups;
        logic bad;
        ups = 0;
        bad = 1'b0;
        for (int p = 0; p < PHASES; p++) begin
            if (to[p*LVL_W +: LVL_W] == from[p*LVL_W +: LVL_W] + lvl_t'(1))
                ups++;
            else if (to[p*LVL_W +: LVL_W] != from[p*LVL_W +: LVL_W])
                bad = 1'b1;
        end
        return !bad && (ups == 1);
    endfunction

    // Gate byte {S11,S12,S13,S14,S21,S22,S23,S24} for one level code
    function automatic logic [7:0] leg_gates(input lvl_t code);
        case (code)
            3'd0:    return 8'hC3;
            3'd1:    return 8'h63;
            3'd3:    return 8'h36;
            3'd4:    return 8'h3C;
            default: return 8'h66;
        endcase
    endfunction

endpackage

// File: rtl/hnpc_seq7_select.sv
// Combinational search for a single-step seven-segment ordering.
// Takes zero states lowest first and two active vertices, each with redundant
// states. Tries every adjacent zero pair; a later (higher) start index
// overrides an earlier one, so the highest feasible pair wins.
module hnpc_seq7_select
    import hnpc_seq7_pkg::*;
#(
    parameter int NZR = 5,
    parameter int NAR = 4,
    localparam int ZCW = $clog2(NZR + 1),
    localparam int ACW = $clog2(NAR + 1)
) (
    input  logic [NZR*ST_W-1:0] zero_set_i,
    input  logic [ZCW-1:0]      zero_cnt_i,
    input  logic [NAR*ST_W-1:0] vtx_a_i,
    input  logic [ACW-1:0]      vtx_a_cnt_i,
    input  logic [NAR*ST_W-1:0] vtx_b_i,
    input  logic [ACW-1:0]      vtx_b_cnt_i,
    output logic                found_o,
    output state_t              z0_o,
    output state_t              v1_o,
    output state_t              v2_o,
    output state_t              z1_o
);

    // Exhaustive search over start index, vertex order and redundancy choice
    always_comb begin
        state_t za, zb, fa, fb;
        int     cf, cs;
        found_o = 1'b0;
        z0_o = '0;
        v1_o = '0;
        v2_o = '0;
        z1_o = '0;
        for (int i = 0; i < NZR - 1; i++) begin
            za = zero_set_i[i*ST_W +: ST_W];
            zb = zero_set_i[(i+1)*ST_W +: ST_W];
            for (int ord = 0; ord < 2; ord++) begin
                cf = (ord == 0) ? int'(vtx_a_cnt_i) : int'(vtx_b_cnt_i);
                cs = (ord == 0) ? int'(vtx_b_cnt_i) : int'(vtx_a_cnt_i);
                for (int j = 0; j < NAR; j++) begin
                    fa = (ord == 0) ? vtx_a_i[j*ST_W +: ST_W] : vtx_b_i[j*ST_W +: ST_W];
                    for (int k = 0; k < NAR; k++) begin
                        fb = (ord == 0) ? vtx_b_i[k*ST_W +: ST_W] : vtx_a_i[k*ST_W +: ST_W];
                        if ((i + 1 < int'(zero_cnt_i)) && (j < cf) && (k < cs) &&
                            step_up(za, fa) && step_up(fa, fb) && step_up(fb, zb)) begin
                            found_o = 1'b1;
                            z0_o = za;
                            v1_o = fa;
                            v2_o = fb;
                            z1_o = zb;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hnpc_seq7_timer.sv
// Period counter and segment timing for the seven-segment pattern.
// On the boundary cycle it clamps the dwell inputs, splits them into seven
// lengths and latches the cumulative boundaries. It assumes PERIOD >= 8.
module hnpc_seq7_timer #(
    parameter int PERIOD = 50000,
    localparam int TW = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] t1_i,
    input  logic [TW-1:0] t2_i,
    output logic          load_o,
    output logic [TW-1:0] cnt_o,
    output logic [2:0]    seg_o,
    output logic          full_o
);

    localparam logic [TW-1:0] P_V    = TW'(PERIOD);
    localparam logic [TW-1:0] LAST_V = TW'(PERIOD - 1);
    localparam int            NSEG   = 7;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] t1c, t2c, t0, rem;
    logic [TW-1:0] len  [NSEG];
    logic [TW-1:0] bnd  [1:NSEG-1];
    logic [TW-1:0] bnd_q[1:NSEG-1];
    logic          all_pos;
    logic          full_q;

    assign load_o = (cnt_q == LAST_V);
    assign cnt_o  = cnt_q;
    assign full_o = full_q;

    // Clamp dwell times and derive the seven segment lengths
    always_comb begin
        t1c = (t1_i > P_V) ? P_V : t1_i;
        rem = P_V - t1c;
        t2c = (t2_i > rem) ? rem : t2_i;
        t0  = P_V - t1c - t2c;
        len[0] = t0 >> 2;
        len[1] = t1c >> 1;
        len[2] = t2c >> 1;
        len[3] = t0 - (t0 >> 1);
        len[4] = t2c - (t2c >> 1);
        len[5] = t1c - (t1c >> 1);
        len[6] = (t0 >> 1) - (t0 >> 2);
    end

    // Running boundary sums, one per segment change
    generate
        for (genvar s = 1; s < NSEG; s++) begin : g_bnd
            if (s == 1) begin : g_first
                assign bnd[s] = len[0];
            end else begin : g_rest
                assign bnd[s] = bnd[s-1] + len[s-1];
            end
        end
    endgenerate

    // All seven segments occupy at least one cycle
    always_comb begin
        all_pos = 1'b1;
        for (int s = 0; s < NSEG; s++)
            if (len[s] == '0) all_pos = 1'b0;
    end

    // Period counter; reset parks it on the boundary cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LAST_V;
        else        cnt_q <= load_o ? '0 : cnt_q + TW'(1);
    end

    // Latch boundaries only at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 1; s < NSEG; s++) bnd_q[s] <= P_V;
            full_q <= 1'b0;
        end else if (load_o) begin
            for (int s = 1; s < NSEG; s++) bnd_q[s] <= bnd[s];
            full_q <= all_pos;
        end
    end

    // Segment index: number of boundaries already passed
    always_comb begin
        seg_o = 3'd0;
        for (int s = 1; s < NSEG; s++)
            if (bnd_q[s] <= cnt_q) seg_o = seg_o + 3'd1;
    end

endmodule

// File: rtl/hnpc_seq7_gates.sv
// Level-code to gate-byte decoder, one instance of the table per phase.
// Assumes codes 0..4; any other code maps to the mid level.
module hnpc_seq7_gates
    import hnpc_seq7_pkg::*;
(
    input  state_t                  level_i,
    output logic [PHASES*8-1:0]     gate_o
);

    // One decoder per phase leg pair
    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_leg
            assign gate_o[p*8 +: 8] = leg_gates(level_i[p*LVL_W +: LVL_W]);
        end
    endgenerate

endmodule

// File: rtl/hnpc_seq7.sv
// Seven-segment switching sequencer for a five-level H-bridge inverter.
// Selects a single-step ordering among redundant states, latches it with the
// dwell split at each period boundary, plays Z0 V1 V2 Z1 V2 V1 Z0, and
// decodes levels to gate bits. When no ordering exists it holds its outputs.
module hnpc_seq7
    import hnpc_seq7_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int SW_HZ  = 2000,
    parameter int PERIOD = CLK_HZ / SW_HZ,
    parameter int NZR    = 5,
    parameter int NAR    = 4,
    localparam int TW    = $clog2(PERIOD + 1),
    localparam int ZCW   = $clog2(NZR + 1),
    localparam int ACW   = $clog2(NAR + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NZR*9-1:0]    zero_set_i,
    input  logic [ZCW-1:0]      zero_cnt_i,
    input  logic [NAR*9-1:0]    vtx_a_i,
    input  logic [ACW-1:0]      vtx_a_cnt_i,
    input  logic [NAR*9-1:0]    vtx_b_i,
    input  logic [ACW-1:0]      vtx_b_cnt_i,
    input  logic [TW-1:0]       t1_i,
    input  logic [TW-1:0]       t2_i,
    output logic [8:0]          level_o,
    output logic [23:0]         gate_o,
    output logic                err_o
);

    localparam state_t MID = 9'o222;

    logic          found;
    state_t        s_z0, s_v1, s_v2, s_z1;
    state_t        p_z0, p_v1, p_v2, p_z1;
    state_t        seg_state, lvl_q;
    logic          load, full_seq;
    logic [TW-1:0] seq_cnt;
    logic [2:0]    seg;
    logic          err_q, err_out_q;

    hnpc_seq7_select #(.NZR(NZR), .NAR(NAR)) u_select (
        .zero_set_i (zero_set_i),
        .zero_cnt_i (zero_cnt_i),
        .vtx_a_i    (vtx_a_i),
        .vtx_a_cnt_i(vtx_a_cnt_i),
        .vtx_b_i    (vtx_b_i),
        .vtx_b_cnt_i(vtx_b_cnt_i),
        .found_o    (found),
        .z0_o       (s_z0),
        .v1_o       (s_v1),
        .v2_o       (s_v2),
        .z1_o       (s_z1)
    );

    hnpc_seq7_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .t1_i  (t1_i),
        .t2_i  (t2_i),
        .load_o(load),
        .cnt_o (seq_cnt),
        .seg_o (seg),
        .full_o(full_seq)
    );

    // Latch the chosen states at the boundary; keep the old plan on failure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_z0  <= MID;
            p_v1  <= MID;
            p_v2  <= MID;
            p_z1  <= MID;
            err_q <= 1'b0;
        end else if (load) begin
            err_q <= !found;
            if (found) begin
                p_z0 <= s_z0;
                p_v1 <= s_v1;
                p_v2 <= s_v2;
                p_z1 <= s_z1;
            end
        end
    end

    // Map the segment index onto the symmetric state order
    always_comb begin
        case (seg)
            3'd1, 3'd5: seg_state = p_v1;
            3'd2, 3'd4: seg_state = p_v2;
            3'd3:       seg_state = p_z1;
            default:    seg_state = p_z0;
        endcase
    end

    // Output level register, frozen while the current period is in error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= MID;
            err_out_q <= 1'b0;
        end else begin
            if (!err_q) lvl_q <= seg_state;
            err_out_q <= err_q;
        end
    end

    hnpc_seq7_gates u_gates (
        .level_i(lvl_q),
        .gate_o (gate_o)
    );

    assign level_o = lvl_q;
    assign err_o   = err_out_q;

endmodule

// File: rtl/hnpc_seq7_chk.sv
// Assertion checker for hnpc_seq7, attached through bind.
// Observes ports plus the period counter and the full-pattern flag.
module hnpc_seq7_chk
    import hnpc_seq7_pkg::*;
#(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [8:0]    level_o,
    input logic [23:0]   gate_o,
    input logic          err_o,
    input logic [TW-1:0] seq_cnt,
    input logic          full_seq
);

    logic legs_ok;

    // Complementary switch pairs in every NPC leg
    always_comb begin
        legs_ok = 1'b1;
        for (int p = 0; p < 3; p++) begin
            if (!(gate_o[p*8+7] ^ gate_o[p*8+5])) legs_ok = 1'b0;
            if (!(gate_o[p*8+6] ^ gate_o[p*8+4])) legs_ok = 1'b0;
            if (!(gate_o[p*8+3] ^ gate_o[p*8+1])) legs_ok = 1'b0;
            if (!(gate_o[p*8+2] ^ gate_o[p*8+0])) legs_ok = 1'b0;
        end
    end

    // R9: single-phase single-level steps inside a full-length period
    p_one_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_seq && seq_cnt > TW'(1)) |->
            (($past(level_o) == level_o) || step_up($past(level_o), level_o)
             || step_up(level_o, $past(level_o))));

    // R10: leg pairs always complementary
    p_leg_pairs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        legs_ok);

    // R8: outputs frozen while the error flag is up
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(level_o));

    // R7: the error flag moves only on the edge after a boundary
    p_err_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_o) |-> (seq_cnt == TW'(1)));

endmodule

bind hnpc_seq7 hnpc_seq7_chk #(.TW(TW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_o (level_o),
    .gate_o  (gate_o),
    .err_o   (err_o),
    .seq_cnt (seq_cnt),
    .full_seq(full_seq)
);

// File: tb/hnpc_seq7_bench.sv
// Scoreboard bench: a driver pushes per-cycle expected levels, a monitor
// pops them one cycle at a time and compares against the outputs.
module hnpc_seq7_bench;

    localparam int P   = 40;
    localparam int NZR = 5;
    localparam int NAR = 4;
    localparam int TW  = $clog2(P + 1);
    localparam int ZCW = $clog2(NZR + 1);
    localparam int ACW = $clog2(NAR + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NZR*9-1:0] zero_set;
    logic [ZCW-1:0]   zero_cnt;
    logic [NAR*9-1:0] vtx_a, vtx_b;
    logic [ACW-1:0]   vtx_a_cnt, vtx_b_cnt;
    logic [TW-1:0]    t1, t2;
    logic [8:0]       level_o;
    logic [23:0]      gate_o;
    logic             err_o;

    always #5 clk = ~clk;

    hnpc_seq7 #(.PERIOD(P), .NZR(NZR), .NAR(NAR)) u_hnpc_seq7 (
        .clk(clk), .rst_n(rst_n),
        .zero_set_i(zero_set), .zero_cnt_i(zero_cnt),
        .vtx_a_i(vtx_a), .vtx_a_cnt_i(vtx_a_cnt),
        .vtx_b_i(vtx_b), .vtx_b_cnt_i(vtx_b_cnt),
        .t1_i(t1), .t2_i(t2),
        .level_o(level_o), .gate_o(gate_o), .err_o(err_o)
    );

    typedef struct {
        logic [8:0] lvl;
        logic       err;
        logic       step;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         fails = 0;
    logic [8:0] prev_last = 9'o222;
    bit         done = 0;

    function automatic logic [23:0] exp_gates(input logic [8:0] l);
        logic [7:0] tbl [5] = '{8'hC3, 8'h63, 8'h66, 8'h36, 8'h3C};
        return {tbl[l[8:6]], tbl[l[5:3]], tbl[l[2:0]]};
    endfunction

    function automatic bit one_move(input logic [8:0] a, input logic [8:0] b);
        int moved = 0;
        bit ok = 1;
        for (int p = 0; p < 3; p++) begin
            int d = int'(b[p*3 +: 3]) - int'(a[p*3 +: 3]);
            if (d != 0) moved++;
            if (d > 1 || d < -1) ok = 0;
        end
        return ok && moved <= 1;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_in(input logic [8:0] z [NZR], input int zc,
                          input logic [8:0] a [NAR], input int ac,
                          input logic [8:0] b [NAR], input int bc,
                          input int d1, input int d2);
        for (int k = 0; k < NZR; k++) zero_set[k*9 +: 9] = z[k];
        for (int k = 0; k < NAR; k++) begin
            vtx_a[k*9 +: 9] = a[k];
            vtx_b[k*9 +: 9] = b[k];
        end
        zero_cnt  = ZCW'(zc);
        vtx_a_cnt = ACW'(ac);
        vtx_b_cnt = ACW'(bc);
        t1 = TW'(d1);
        t2 = TW'(d2);
    endtask

    // Expected per-cycle levels for one period, from the split rules
    task automatic push_case(input string tag, input bit ok,
                             input logic [8:0] z0, input logic [8:0] v1,
                             input logic [8:0] v2, input logic [8:0] z1,
                             input int d1, input int d2);
        int c1, c2, c0;
        int lens [7];
        logic [8:0] st [7];
        bit full;
        item_t it;
        if (!ok) begin
            for (int j = 0; j < P; j++) begin
                it = '{lvl: prev_last, err: 1'b1, step: 1'b0, tag: tag};
                sb.push_back(it);
            end
            return;
        end
        c1 = (d1 > P) ? P : d1;
        c2 = (d2 > P - c1) ? P - c1 : d2;
        c0 = P - c1 - c2;
        lens = '{c0/4, c1/2, c2/2, c0 - c0/2, c2 - c2/2, c1 - c1/2, c0/2 - c0/4};
        st   = '{z0, v1, v2, z1, v2, v1, z0};
        full = 1;
        for (int s = 0; s < 7; s++) if (lens[s] == 0) full = 0;
        for (int s = 0; s < 7; s++) begin
            for (int n = 0; n < lens[s]; n++) begin
                it = '{lvl: st[s], err: 1'b0, step: full, tag: tag};
                sb.push_back(it);
                prev_last = st[s];
            end
        end
        // the first cycle of a period is not a within-period step
        sb[sb.size() - P].step = 1'b0;
    endtask

    // Monitor: one comparison set per output cycle after the first boundary
    initial begin
        item_t it;
        logic [8:0] last_act;
        last_act = 9'o222;
        wait (rst_n === 1'b1);
        @(posedge clk);
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(it.tag, "level", 32'(level_o), 32'(it.lvl));
                check({it.tag, " R2 R10"}, "gates", 32'(gate_o), 32'(exp_gates(it.lvl)));
                check({it.tag, " R8"}, "err", 32'(err_o), 32'(it.err));
                if (it.step)
                    check("R9", "single step", 32'(one_move(last_act, level_o)), 32'd1);
            end
            last_act = level_o;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Driver: each next case is applied halfway through the prior period (R7)
    initial begin
        set_in('{9'o210, 9'o321, 9'o432, 0, 0}, 3,
               '{9'o310, 9'o421, 0, 0}, 2, '{9'o320, 9'o431, 0, 0}, 2, 8, 12);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset level", 32'(level_o), 32'(9'o222));
        check("R1", "reset gates", 32'(gate_o), 32'h666666);
        check("R1", "reset err", 32'(err_o), 32'd0);
        // R3 R4 R5: doc-style triangle, start must be 321 not 432
        push_case("R3 R4 R5", 1, 9'o321, 9'o421, 9'o431, 9'o432, 8, 12);
        rst_n = 1'b1;
        @(posedge clk);

        for (int c = 1; c < 9; c++) begin
            repeat (P/2) @(posedge clk);
            #1;
            case (c)
                1: begin // R3 R7: active vertices offered in swapped order
                    set_in('{9'o210, 9'o321, 9'o432, 0, 0}, 3,
                           '{9'o320, 9'o431, 0, 0}, 2, '{9'o310, 9'o421, 0, 0}, 2, 10, 6);
                    push_case("R3 R7", 1, 9'o321, 9'o421, 9'o431, 9'o432, 10, 6);
                end
                2: begin // R4: five zero states, highest non-last start
                    set_in('{9'o000, 9'o111, 9'o222, 9'o333, 9'o444}, 5,
                           '{9'o100, 9'o211, 9'o322, 9'o433}, 4,
                           '{9'o110, 9'o221, 9'o332, 9'o443}, 4, 6, 10);
                    push_case("R4", 1, 9'o333, 9'o433, 9'o443, 9'o444, 6, 10);
                end
                3: begin // R8: no single-step ordering
                    set_in('{9'o210, 9'o321, 0, 0, 0}, 2,
                           '{9'o300, 0, 0, 0}, 1, '{9'o320, 0, 0, 0}, 1, 8, 8);
                    push_case("R8", 0, 0, 0, 0, 0, 0, 0);
                end
                4: begin // R8: a single zero state is also infeasible
                    set_in('{9'o222, 0, 0, 0, 0}, 1,
                           '{9'o322, 0, 0, 0}, 1, '{9'o332, 0, 0, 0}, 1, 8, 8);
                    push_case("R8", 0, 0, 0, 0, 0, 0, 0);
                end
                5: begin // R4: only the lowest pair fits; recovery from error
                    set_in('{9'o000, 9'o111, 9'o222, 0, 0}, 3,
                           '{9'o100, 0, 0, 0}, 1, '{9'o110, 0, 0, 0}, 1, 4, 4);
                    push_case("R4 R8", 1, 9'o000, 9'o100, 9'o110, 9'o111, 4, 4);
                end
                6: begin // R6: T1+T2 over the period, T2 trimmed
                    set_in('{9'o100, 9'o211, 0, 0, 0}, 2,
                           '{9'o110, 0, 0, 0}, 1, '{9'o111, 0, 0, 0}, 1, 30, 20);
                    push_case("R6", 1, 9'o100, 9'o110, 9'o111, 9'o211, 30, 20);
                end
                7: begin // R6: T1 alone over the period
                    set_in('{9'o100, 9'o211, 0, 0, 0}, 2,
                           '{9'o110, 0, 0, 0}, 1, '{9'o111, 0, 0, 0}, 1, 50, 5);
                    push_case("R6", 1, 9'o100, 9'o110, 9'o111, 9'o211, 50, 5);
                end
                default: begin // R5: odd dwell values, uneven halves
                    set_in('{9'o210, 9'o321, 9'o432, 0, 0}, 3,
                           '{9'o310, 9'o421, 0, 0}, 2, '{9'o320, 9'o431, 0, 0}, 2, 7, 10);
                    push_case("R5", 1, 9'o321, 9'o421, 9'o431, 9'o432, 7, 10);
                end
            endcase
            repeat (P - P/2) @(posedge clk);
        end

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule